// File: doc/BRIEF.md
# Infrared Controller Host Register Bank

This block is the host-facing register bank of a serial infrared communications engine. A 3-bit address selects one of eight byte-wide locations. They are a data port into a shared 16-entry byte queue, an interrupt identification register, an interrupt enable register, two line control registers, a read-only status register and two reserved slots. The host side reads and writes through a chip select with separate read and write strobes. The engine side pushes received bytes into the queue and pops bytes for transmit through its own port.

Access to the queue through the data port is gated. Host reads always reach the queue, but a read of an empty queue returns zero and pops nothing. Host writes reach the queue only when loopback is off and the engine is either idle or has transmit enabled. A write to a full queue is dropped. The identification register shows the raw state of each interrupt source. The only exception is the queue source, which is qualified by its own enable. A master enable and the per-source enables decide whether the single interrupt request output is driven.

Register layout (the control bits appear inside the requirements): 0 data port, 1 identification (read-only), 2 interrupt enable, 3 line control A, 4 line control B, 5 status (read-only), 6 and 7 reserved.

Top module: `ir_host_bank`

## Requirements
- R1: After reset, every address reads 00h, `irq` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A host write to address 0 pushes `wdata` only when loopback (line control A bit 3) is 0 and either the mode field (line control A bits 1:0) is 00 or transmit enable (line control A bit 2) is 1. Otherwise the write is dropped.
- R3: The queue holds 16 bytes. `fifo_full` rises when the 16th byte is stored, and a host write while full is dropped.
- R4: A host read of address 0 returns the oldest byte and pops it, whatever the mode, transmit-enable and loopback values are.
- R5: Reading address 0 while the queue is empty returns 00h and does not pop, so later data are stored and returned in order.
- R6: Identification bits 4:1 show event inputs `ev_i[3:0]` whatever the enables say, and writes to address 1 are ignored.
- R7: Identification bit 0 is 1 only when the queue is not empty and its enable (interrupt enable bit 0) is 1.
- R8: `irq` equals master enable (interrupt enable bit 7) AND the OR over bits 4:0 of (identification AND interrupt enable).
- R9: Reserved bits read 0 and ignore writes: interrupt enable bits 6:5, line control A bits 7:4 and all of addresses 6 and 7. Line control B keeps all 8 bits.
- R10: A register write takes effect only on a clock edge where both `cs` and `wr` are 1. Reads are combinational from `addr`.
- R11: The engine port pushes `eng_wdata` when the queue is not full, and `eng_pop` removes the byte shown on `eng_rdata`. When the host and the engine push in the same cycle, only the host byte is stored.
- R12: Address 5 reads `stat_i` and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (pops the queue at address 0) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| irq | output | 1 | Interrupt request |
| ev_i | input | 4 | Raw interrupt event sources 1..4 |
| stat_i | input | 8 | Engine status shown at address 5 |
| mode_o | output | 2 | Mode field of line control A |
| tx_en_o | output | 1 | Transmit enable |
| loop_o | output | 1 | Loopback |
| ctrl_b_o | output | 8 | Line control B |
| eng_push | input | 1 | Engine push request |
| eng_wdata | input | 8 | Engine push data |
| eng_pop | input | 1 | Engine pop request |
| eng_rdata | output | 8 | Oldest queue byte |
| fifo_full | output | 1 | Queue full flag |
| fifo_empty | output | 1 | Queue empty flag |

## Verification
The bench builds the block with its defaults: a 16-entry queue and five interrupt sources. At this size the whole space can be swept. That covers all sixteen combinations of mode, transmit enable and loopback for write gating, and every event pattern against every enable pattern with the queue both empty and filled, which is 2048 identification and request cases. The 16-entry depth lets the bench fill the queue to the brim, push one byte past it and drain it in order, and then read once more from the empty queue.

// File: rtl/ir_bank_pkg.sv
package ir_bank_pkg;
  localparam int unsigned BW = 8;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_IDENT = 3'd1;
  localparam logic [2:0] ADDR_IEN   = 3'd2;
  localparam logic [2:0] ADDR_LCA   = 3'd3;
  localparam logic [2:0] ADDR_LCB   = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FAST = 2'd1,
    MODE_CONS = 2'd2,
    MODE_RAW  = 2'd3
  } ir_mode_e;

  localparam int unsigned LCA_TXEN_BIT = 2;
  localparam int unsigned LCA_LOOP_BIT = 3;
  localparam int unsigned IEN_MSTR_BIT = 7;
endpackage

// File: rtl/ir_fifo.sv
module ir_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d, empty_q, empty_d;
  logic          push_ok, pop_ok;

  assign push_ok = push & ~full_q;
  assign pop_ok  = pop & ~empty_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    empty_d = (cnt_d == '0);
    full_d  = (cnt_d == CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  assign head  = mem[rp_q];
  assign full  = full_q;
  assign empty = empty_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/ir_port_gate.sv
module ir_port_gate
  import ir_bank_pkg::*;
(
  input  logic     cs,
  input  logic     wr,
  input  logic     rd,
  input  logic [2:0] addr,
  input  ir_mode_e mode,
  input  logic     tx_en,
  input  logic     loop,
  input  logic     full,
  input  logic     empty,
  input  logic     eng_push,
  input  logic     eng_pop,
  output logic     push,
  output logic     push_host,
  output logic     pop
);
  logic data_sel, host_wr_ok, host_rd_ok, wr_mode_ok;

  assign data_sel   = cs & (addr == ADDR_DATA);
  assign wr_mode_ok = ~loop & ((mode == MODE_IDLE) | tx_en);
  assign host_wr_ok = data_sel & wr & wr_mode_ok & ~full;
  assign host_rd_ok = data_sel & rd & ~empty;

  assign push_host = host_wr_ok;
  assign push      = host_wr_ok | (eng_push & ~full);
  assign pop       = host_rd_ok | (eng_pop & ~empty);
endmodule

// File: rtl/ir_irq_unit.sv
module ir_irq_unit #(
  parameter int unsigned NSRC = 5
) (
  input  logic            fifo_cond,
  input  logic [NSRC-2:0] ev,
  input  logic [NSRC-1:0] en,
  input  logic            master,
  output logic [NSRC-1:0] ident,
  output logic            irq
);
  assign ident[0] = fifo_cond & en[0];

  for (genvar i = 1; i < NSRC; i++) begin : g_raw
    assign ident[i] = ev[i-1];
  end

  assign irq = master & (|(ident & en));
endmodule

// File: rtl/ir_host_bank.sv
module ir_host_bank
  import ir_bank_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NSRC  = 5,
  localparam int unsigned CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1,
  localparam logic [BW-1:0] IEN_MASK = (BW'(1) << IEN_MSTR_BIT) | ((BW'(1) << NSRC) - BW'(1)),
  localparam logic [BW-1:0] LCA_MASK = BW'(8'h0F)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            wr,
  input  logic            rd,
  input  logic [2:0]      addr,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  output logic            irq,
  input  logic [NSRC-2:0] ev_i,
  input  logic [BW-1:0]   stat_i,
  output logic [1:0]      mode_o,
  output logic            tx_en_o,
  output logic            loop_o,
  output logic [BW-1:0]   ctrl_b_o,
  input  logic            eng_push,
  input  logic [BW-1:0]   eng_wdata,
  input  logic            eng_pop,
  output logic [BW-1:0]   eng_rdata,
  output logic            fifo_full,
  output logic            fifo_empty
);
  logic [BW-1:0]   ien_q, ien_d, lca_q, lca_d, lcb_q, lcb_d;
  logic            we;
  logic            q_push, q_push_host, q_pop;
  logic [BW-1:0]   q_din, q_head;
  logic [CW-1:0]   fifo_cnt;
  logic [NSRC-1:0] ident_w;
  ir_mode_e        mode_w;

  assign we     = cs & wr;
  assign mode_w = ir_mode_e'(lca_q[1:0]);

  always_comb begin
    ien_d = ien_q;
    lca_d = lca_q;
    lcb_d = lcb_q;
    if (we) begin
      unique case (addr)
        ADDR_IEN: ien_d = wdata & IEN_MASK;
        ADDR_LCA: lca_d = wdata & LCA_MASK;
        ADDR_LCB: lcb_d = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      lca_q <= '0;
      lcb_q <= '0;
    end else begin
      ien_q <= ien_d;
      lca_q <= lca_d;
      lcb_q <= lcb_d;
    end
  end

  ir_port_gate u_gate (
    .cs        (cs),
    .wr        (wr),
    .rd        (rd),
    .addr      (addr),
    .mode      (mode_w),
    .tx_en     (lca_q[LCA_TXEN_BIT]),
    .loop      (lca_q[LCA_LOOP_BIT]),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .eng_push  (eng_push),
    .eng_pop   (eng_pop),
    .push      (q_push),
    .push_host (q_push_host),
    .pop       (q_pop)
  );

  assign q_din = q_push_host ? wdata : eng_wdata;

  ir_fifo #(.DEPTH(DEPTH), .W(BW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .head  (q_head),
    .full  (fifo_full),
    .empty (fifo_empty),
    .cnt   (fifo_cnt)
  );

  ir_irq_unit #(.NSRC(NSRC)) u_irq (
    .fifo_cond (~fifo_empty),
    .ev        (ev_i),
    .en        (ien_q[NSRC-1:0]),
    .master    (ien_q[IEN_MSTR_BIT]),
    .ident     (ident_w),
    .irq       (irq)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_DATA:  rdata = fifo_empty ? '0 : q_head;
      ADDR_IDENT: rdata = BW'(ident_w);
      ADDR_IEN:   rdata = ien_q;
      ADDR_LCA:   rdata = lca_q;
      ADDR_LCB:   rdata = lcb_q;
      ADDR_STAT:  rdata = stat_i;
      default:    rdata = '0;
    endcase
  end

  assign mode_o    = lca_q[1:0];
  assign tx_en_o   = lca_q[LCA_TXEN_BIT];
  assign loop_o    = lca_q[LCA_LOOP_BIT];
  assign ctrl_b_o  = lcb_q;
  assign eng_rdata = q_head;
endmodule

// File: rtl/ir_host_bank_chk.sv
module ir_host_bank_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NSRC  = 5,
  localparam int unsigned CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            wr,
  input logic            rd,
  input logic [2:0]      addr,
  input logic            irq,
  input logic            fifo_full,
  input logic            fifo_empty,
  input logic            eng_push,
  input logic            eng_pop,
  input logic [7:0]      ien_q,
  input logic [7:0]      lca_q,
  input logic [NSRC-1:0] ident_w,
  input logic [CW-1:0]   fifo_cnt
);
  logic host_wr0, host_rd0;
  assign host_wr0 = cs & wr & (addr == 3'd0);
  assign host_rd0 = cs & rd & (addr == 3'd0);

  // R3
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_empty);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !eng_pop && !host_rd0 |=> fifo_full);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && !eng_push && !host_wr0 |=> fifo_empty);

  // R2
  loop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lca_q[3] && host_wr0 && !eng_push && !eng_pop && !host_rd0 |=> fifo_cnt == $past(fifo_cnt));

  // R7
  fifo_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !ident_w[0]);

  // R8
  irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q[7] |-> !irq);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ident_w & ien_q[NSRC-1:0]) == '0) |-> !irq);
endmodule

bind ir_host_bank ir_host_bank_chk #(.DEPTH(DEPTH), .NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .wr         (wr),
  .rd         (rd),
  .addr       (addr),
  .irq        (irq),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .eng_push   (eng_push),
  .eng_pop    (eng_pop),
  .ien_q      (ien_q),
  .lca_q      (lca_q),
  .ident_w    (ident_w),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/sim_ir_host_bank.sv
module sim_ir_host_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic       clk, rst_n, cs, wr, rd;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, stat_i, ctrl_b_o, eng_wdata, eng_rdata;
  logic [3:0] ev_i;
  logic [1:0] mode_o;
  logic       irq, tx_en_o, loop_o, eng_push, eng_pop, fifo_full, fifo_empty;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  ir_host_bank u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .ev_i(ev_i), .stat_i(stat_i),
    .mode_o(mode_o), .tx_en_o(tx_en_o), .loop_o(loop_o), .ctrl_b_o(ctrl_b_o),
    .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
    .eng_rdata(eng_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_CYC && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WDOG_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  initial begin
    logic [7:0] v, expv;
    cs = 0; wr = 0; rd = 0; addr = 0; wdata = 0; ev_i = 0; stat_i = 0;
    eng_push = 0; eng_pop = 0; eng_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of every address and flag
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), v);
      check("R1 read", v, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 empty", {7'd0, fifo_empty}, 8'h01);
    check("R1 full", {7'd0, fifo_full}, 8'h00);

    // R9, R6, R12: write all ones everywhere except the data port
    for (int a = 1; a < 8; a++) bus_wr(3'(a), 8'hFF);
    bus_rd(3'd1, v); check("R6 ident write ignored", v, 8'h00);
    bus_rd(3'd2, v); check("R9 ien mask", v, 8'h9F);
    bus_rd(3'd3, v); check("R9 lca mask", v, 8'h0F);
    bus_rd(3'd4, v); check("R9 lcb full width", v, 8'hFF);
    bus_rd(3'd5, v); check("R12 stat write ignored", v, 8'h00);
    bus_rd(3'd6, v); check("R9 addr6", v, 8'h00);
    bus_rd(3'd7, v); check("R9 addr7", v, 8'h00);
    check("R9 ctrl outputs", {mode_o, tx_en_o, loop_o, 4'd0}, 8'hF0);
    bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h00); bus_wr(3'd4, 8'h00);

    // R10: strobes alone do not write
    @(negedge clk); cs = 1; wr = 0; addr = 3'd4; wdata = 8'h55;
    @(negedge clk); cs = 0; wr = 1;
    @(negedge clk); wr = 0;
    check("R10 no write without cs&wr", ctrl_b_o, 8'h00);
    bus_wr(3'd4, 8'h3C);
    check("R10 write with cs&wr", ctrl_b_o, 8'h3C);

    // R12: status pass-through
    stat_i = 8'hA5;
    bus_rd(3'd5, v); check("R12 status", v, 8'hA5);

    // R2: sweep line control A
    for (int l = 0; l < 16; l++) begin
      bit ok;
      ok = (l[3] == 1'b0) && ((l[1:0] == 2'b00) || l[2]);
      bus_wr(3'd3, 8'(l));
      bus_wr(3'd0, 8'(8'h10 + l));
      check("R2 gating", {7'd0, fifo_empty}, {7'd0, !ok});
      if (ok) begin
        bus_rd(3'd0, v);
        check("R2 stored byte", v, 8'(8'h10 + l));
      end
    end

    // R3: fill, overflow, then R4 drain with loopback set
    bus_wr(3'd3, 8'h00);
    for (int i = 0; i < 17; i++) begin
      bus_wr(3'd0, 8'(i * 7 + 3));
      if (i == 14) check("R3 not full at 15", {7'd0, fifo_full}, 8'h00);
      if (i == 15) check("R3 full at 16", {7'd0, fifo_full}, 8'h01);
    end
    bus_wr(3'd3, 8'h0A);
    for (int i = 0; i < 16; i++) begin
      bus_rd(3'd0, v);
      check("R4 drain order", v, 8'(i * 7 + 3));
    end
    check("R3 17th dropped", {7'd0, fifo_empty}, 8'h01);

    // R5: empty read
    bus_rd(3'd0, v); check("R5 empty read", v, 8'h00);
    check("R5 stays empty", {7'd0, fifo_empty}, 8'h01);
    bus_wr(3'd3, 8'h00);
    bus_wr(3'd0, 8'h77); bus_wr(3'd0, 8'h78);
    bus_rd(3'd0, v); check("R5 order after empty read", v, 8'h77);
    bus_rd(3'd0, v); check("R5 order after empty read", v, 8'h78);

    // R6, R7, R8 sweep
    for (int f = 0; f < 2; f++) begin
      if (f == 1) bus_wr(3'd0, 8'h42);
      for (int e = 0; e < 64; e++) begin
        logic [7:0] ien;
        ien = {e[5], 2'b00, e[4:0]};
        bus_wr(3'd2, ien);
        for (int s = 0; s < 16; s++) begin
          logic [4:0] id;
          @(negedge clk); ev_i = 4'(s);
          id = {4'(s), (f == 1) & e[0]};
          #1;
          addr = 3'd1;
          #1;
          check("R6 R7 ident", rdata, {3'd0, id});
          check("R8 irq", {7'd0, irq}, {7'd0, e[5] & (|(id & 5'(e[4:0])))});
        end
      end
    end
    ev_i = 0;
    bus_wr(3'd2, 8'h00);
    bus_rd(3'd0, v); check("R4 sweep byte", v, 8'h42);

    // R11: engine port
    @(negedge clk); eng_push = 1; eng_wdata = 8'hC1;
    @(negedge clk); eng_wdata = 8'hC2;
    @(negedge clk); eng_push = 0;
    check("R11 engine head", eng_rdata, 8'hC1);
    @(negedge clk); eng_pop = 1;
    @(negedge clk); eng_pop = 0;
    bus_rd(3'd0, v); check("R11 after engine pop", v, 8'hC2);
    check("R11 drained", {7'd0, fifo_empty}, 8'h01);
    @(negedge clk); cs = 1; wr = 1; addr = 3'd0; wdata = 8'hAA;
    eng_push = 1; eng_wdata = 8'hBB;
    @(negedge clk); cs = 0; wr = 0; eng_push = 0;
    bus_rd(3'd0, v); check("R11 host priority", v, 8'hAA);
    check("R11 single entry", {7'd0, fifo_empty}, 8'h01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule